// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Responder

This block is the device side of a single-wire, open-drain bus. It watches the shared line, which idles high through a pull-up. A long low period driven by the bus master is taken as a bus reset. The block answers that reset with a presence pulse, sent after a fixed wait. After that, the master starts every bit slot with a falling edge. That edge launches a microsecond-resolution delay inside the block. When the delay ends, the block either reads the line to capture a written bit, or it stops pulling the line low after sending a 0. When it sends a 1, it never pulls the line.

A small byte stage sits above the bit layer. After every reset, the first byte is taken as a device-selection command. The code 0xCC (skip addressing) selects the device directly, with no 64-bit identity code. It opens the function phase. In that phase, bytes written by the master appear on a parallel output, and bytes offered on a parallel input are sent in read slots. Any other selection code leaves the device silent until the next reset.

All timing runs on a one-cycle strobe that arrives once per microsecond. The line input passes through a flop synchroniser before any edge is detected.

Top module: `swb_slave`

## Requirements
- R1: After the line has been low for 480 tick periods or more, the block treats the low period as a bus reset. Any slot in progress is abandoned and the pull-down is released.
- R2: After the line rises at the end of a reset, the block waits 30 µs and then pulls the line low for 120 µs as a presence pulse.
- R3: In a write slot, the block samples the line 30 µs after the master's falling edge. A line still low then is a 0; a line released earlier is a 1.
- R4: In a read slot, a 0 bit is sent by pulling the line low from the falling edge until 30 µs after it. A 1 bit is sent by never pulling the line. Either way the line is released again by 40 µs.
- R5: Bytes are received and sent least significant bit first.
- R6: If the first byte after a reset is 0xCC, the function phase starts (func_phase = 1). Each later byte written while tx_mode = 0 appears on rx_byte, with rx_strobe high for one cycle.
- R7: If the first byte after a reset is any other value, the function phase does not start. Later written bytes raise no rx_strobe. Read slots leave the line high and raise no tx_taken.
- R8: A reset in the middle of a byte clears the bit position and returns the byte stage to waiting for the selection command, with func_phase = 0.
- R9: The block pulls the line only during a presence pulse or during a read slot that sends a 0. Falling edges that the block causes by its own pulling never start a slot.
- R10: In the function phase with tx_mode = 1, tx_byte bit k is sent in the k-th read slot of the byte. tx_taken pulses for one cycle after the eighth slot.
- R11: A low period of 479 tick periods is not a reset and produces no presence pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| line_in | input | 1 | Raw level of the bus line |
| line_pull | output | 1 | 1 = pull the line low (open-drain drive) |
| func_phase | output | 1 | Skip-addressing accepted; function bytes in use |
| tx_mode | input | 1 | 1 = slots in the function phase are read slots |
| tx_byte | input | 8 | Byte sent in the coming read slots |
| rx_byte | output | 8 | Last byte received in the function phase |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte is updated |
| tx_taken | output | 1 | One-cycle pulse when tx_byte has been fully sent |

## Verification
The hardest cases to reach are the exact reset threshold and a reset that lands part-way through a byte. The bench sets the tick at one per four clocks and drives every low period as an exact number of tick periods. This places low times of 479 and 480 tick periods on either side of the threshold. For the mid-byte case, three bits of a byte are written, then a full reset is driven. The bench then checks that the next selection byte and the data byte after it decode from bit 0.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RST_LOW,
      PH_PD_WAIT,
      PH_PD_DRIVE,
      PH_SLOT
   } phase_t;

   typedef enum logic [1:0] {
      CS_WAIT_RST,
      CS_ROM,
      CS_FUNC,
      CS_HALT
   } cmd_state_t;

   localparam logic [7:0] SKIP_SELECT_CODE = 8'hCC;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          MASK_OWN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   input  logic own_pull,
   output logic line_s,
   output logic fall_ok,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("swb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              prev;
   logic [STAGES:0]   pull_hist;
   logic              quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '1;
         prev      <= 1'b1;
         pull_hist <= '0;
      end else begin
         sh        <= {sh[STAGES-2:0], line_raw};
         prev      <= sh[STAGES-1];
         pull_hist <= {pull_hist[STAGES-1:0], own_pull};
      end
   end

   // Self-caused edges take STAGES+1 cycles to come back through the flops.
   if (MASK_OWN) begin : g_mask
      assign quiet = ~(|pull_hist) & ~own_pull;
   end else begin : g_nomask
      assign quiet = 1'b1;
   end

   assign line_s  = sh[STAGES-1];
   assign fall_ok = prev & ~line_s & quiet;
   assign rise    = ~prev & line_s;

   assert_own_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      own_pull |-> !fall_ok);

endmodule

// File: rtl/swb_timing.sv
module swb_timing
   import swb_pkg::*;
#(
   parameter int unsigned RESET_US   = 480,
   parameter int unsigned PD_WAIT_US = 30,
   parameter int unsigned PD_LEN_US  = 120,
   parameter int unsigned SAMPLE_US  = 30,
   parameter int unsigned HOLD_US    = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line_s,
   input  logic fall_ok,
   input  logic rise,
   input  logic drive_req,
   input  logic drive_bit,
   output logic pull,
   output logic bus_rst,
   output logic bit_evt,
   output logic bit_val,
   output logic rd_done
);

   localparam int unsigned SLOT_END = max2(SAMPLE_US, HOLD_US);
   localparam int unsigned CNT_MAX  = max2(max2(PD_WAIT_US, PD_LEN_US), SLOT_END);
   localparam int unsigned CW       = $clog2(CNT_MAX + 1);
   localparam int unsigned LW       = $clog2(RESET_US + 1);

   if (PD_WAIT_US < 1 || PD_LEN_US < 1 || SAMPLE_US < 1 || HOLD_US < 1) begin : g_bad_time
      $error("swb_timing: every delay must be at least one tick");
   end
   if (RESET_US <= PD_LEN_US + SLOT_END) begin : g_bad_reset
      $error("swb_timing: RESET_US must exceed any low time the block creates");
   end

   phase_t        phase;
   logic [CW-1:0] cnt;
   logic [LW-1:0] lowcnt;
   logic          rd_slot;
   logic          rst_hit;

   assign rst_hit = tick & ~line_s & (lowcnt == LW'(RESET_US - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         lowcnt  <= '0;
         rd_slot <= 1'b0;
         pull    <= 1'b0;
         bus_rst <= 1'b0;
         bit_evt <= 1'b0;
         bit_val <= 1'b0;
         rd_done <= 1'b0;
      end else begin
         bus_rst <= 1'b0;
         bit_evt <= 1'b0;
         rd_done <= 1'b0;

         if (line_s)
            lowcnt <= '0;
         else if (tick && lowcnt != LW'(RESET_US))
            lowcnt <= lowcnt + 1'b1;

         unique case (phase)
            PH_IDLE: begin
               if (fall_ok) begin
                  phase   <= PH_SLOT;
                  cnt     <= '0;
                  rd_slot <= drive_req;
                  pull    <= drive_req & ~drive_bit;
               end
            end
            PH_RST_LOW: begin
               if (rise) begin
                  phase <= PH_PD_WAIT;
                  cnt   <= '0;
               end
            end
            PH_PD_WAIT: begin
               if (tick) begin
                  if (cnt == CW'(PD_WAIT_US - 1)) begin
                     phase <= PH_PD_DRIVE;
                     cnt   <= '0;
                     pull  <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_PD_DRIVE: begin
               if (tick) begin
                  if (cnt == CW'(PD_LEN_US - 1)) begin
                     phase <= PH_IDLE;
                     pull  <= 1'b0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_SLOT: begin
               if (tick) begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CW'(HOLD_US - 1))
                     pull <= 1'b0;
                  if (cnt == CW'(SAMPLE_US - 1) && !rd_slot) begin
                     bit_evt <= 1'b1;
                     bit_val <= line_s;
                  end
                  if (cnt == CW'(SLOT_END - 1)) begin
                     phase   <= PH_IDLE;
                     rd_done <= rd_slot;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase

         // A reset overrides whatever the slot logic chose this cycle.
         if (rst_hit) begin
            phase   <= PH_RST_LOW;
            pull    <= 1'b0;
            bus_rst <= 1'b1;
            bit_evt <= 1'b0;
            rd_done <= 1'b0;
         end
      end
   end

   assert_lowcnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lowcnt <= LW'(RESET_US));
   assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |-> (!pull && phase == PH_RST_LOW));
   assert_presence_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_PD_DRIVE |-> pull);
   assert_pull_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pull |-> (phase == PH_PD_DRIVE || (phase == PH_SLOT && rd_slot)));
   assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_rst, bit_evt, rd_done}));

endmodule

// File: rtl/swb_bytes.sv
module swb_bytes
   import swb_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter logic [DATA_W-1:0] SKIP_CODE = DATA_W'(SKIP_SELECT_CODE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              bit_evt,
   input  logic              bit_val,
   input  logic              rd_done,
   input  logic              tx_mode,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              drive_req,
   output logic              drive_bit,
   output logic              func_phase,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_strobe,
   output logic              tx_taken
);

   localparam int unsigned BW = $clog2(DATA_W);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("swb_bytes: DATA_W must be a power of two, at least 2");
   end

   cmd_state_t        state;
   logic [BW-1:0]     bitcnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] nb;
   logic              last;
   logic              take_bit;

   assign nb       = {bit_val, shreg[DATA_W-1:1]};
   assign last     = (bitcnt == BW'(DATA_W - 1));
   assign take_bit = bit_evt & (state == CS_ROM || state == CS_FUNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CS_WAIT_RST;
         bitcnt    <= '0;
         shreg     <= '0;
         rx_byte   <= '0;
         rx_strobe <= 1'b0;
         tx_taken  <= 1'b0;
      end else begin
         rx_strobe <= 1'b0;
         tx_taken  <= 1'b0;
         if (bus_rst) begin
            state  <= CS_ROM;
            bitcnt <= '0;
            shreg  <= '0;
         end else if (take_bit) begin
            shreg  <= nb;
            bitcnt <= bitcnt + 1'b1;
            if (last) begin
               if (state == CS_ROM) begin
                  state <= (nb == SKIP_CODE) ? CS_FUNC : CS_HALT;
               end else begin
                  rx_byte   <= nb;
                  rx_strobe <= 1'b1;
               end
            end
         end else if (rd_done && state == CS_FUNC) begin
            bitcnt <= bitcnt + 1'b1;
            if (last)
               tx_taken <= 1'b1;
         end
      end
   end

   assign func_phase = (state == CS_FUNC);
   assign drive_req  = func_phase & tx_mode;
   assign drive_bit  = tx_byte[bitcnt];

   assert_clear_on_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rst) |-> (bitcnt == '0 && state == CS_ROM));
   assert_rx_in_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> func_phase);
   assert_taken_in_func_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_taken |-> func_phase);
   assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CS_HALT && !bus_rst) |=> state == CS_HALT);

endmodule

// File: rtl/swb_slave.sv
module swb_slave
   import swb_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MASK_OWN    = 1'b1,
   parameter int unsigned RESET_US    = 480,
   parameter int unsigned PD_WAIT_US  = 30,
   parameter int unsigned PD_LEN_US   = 120,
   parameter int unsigned SAMPLE_US   = 30,
   parameter int unsigned HOLD_US     = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_us,
   input  logic              line_in,
   output logic              line_pull,
   output logic              func_phase,
   input  logic              tx_mode,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_strobe,
   output logic              tx_taken
);

   logic line_s, fall_ok, rise;
   logic bus_rst, bit_evt, bit_val, rd_done;
   logic drive_req, drive_bit;

   swb_sync #(.STAGES(SYNC_STAGES), .MASK_OWN(MASK_OWN)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (line_in),
      .own_pull (line_pull),
      .line_s   (line_s),
      .fall_ok  (fall_ok),
      .rise     (rise)
   );

   swb_timing #(
      .RESET_US   (RESET_US),
      .PD_WAIT_US (PD_WAIT_US),
      .PD_LEN_US  (PD_LEN_US),
      .SAMPLE_US  (SAMPLE_US),
      .HOLD_US    (HOLD_US)
   ) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_us),
      .line_s    (line_s),
      .fall_ok   (fall_ok),
      .rise      (rise),
      .drive_req (drive_req),
      .drive_bit (drive_bit),
      .pull      (line_pull),
      .bus_rst   (bus_rst),
      .bit_evt   (bit_evt),
      .bit_val   (bit_val),
      .rd_done   (rd_done)
   );

   swb_bytes #(.DATA_W(DATA_W)) u_bytes (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_rst    (bus_rst),
      .bit_evt    (bit_evt),
      .bit_val    (bit_val),
      .rd_done    (rd_done),
      .tx_mode    (tx_mode),
      .tx_byte    (tx_byte),
      .drive_req  (drive_req),
      .drive_bit  (drive_bit),
      .func_phase (func_phase),
      .rx_byte    (rx_byte),
      .rx_strobe  (rx_strobe),
      .tx_taken   (tx_taken)
   );

endmodule

// File: tb/sim_swb_slave.sv
`timescale 1ns/1ps
module sim_swb_slave;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_us = 1'b0;
   logic       m_low = 1'b0;
   logic       line;
   logic       line_pull, func_phase, rx_strobe, tx_taken;
   logic       tx_mode = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic [7:0] rx_byte;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rx_n = 0;
   int tk_n = 0;
   int pull_cyc = 0;
   logic [7:0] rx_last = 8'h00;

   always #2.5 clk = ~clk;

   assign line = ~(m_low | line_pull);

   swb_slave u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .line_in(line),
      .line_pull(line_pull), .func_phase(func_phase), .tx_mode(tx_mode),
      .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
      .tx_taken(tx_taken)
   );

   // One tick per four clocks: 1 us = 4 clocks in this bench.
   always @(negedge clk) begin
      cyc     <= cyc + 1;
      tick_us <= (cyc % 4 == 3);
      if (rx_strobe) begin
         rx_n    <= rx_n + 1;
         rx_last <= rx_byte;
      end
      if (tx_taken) tk_n <= tk_n + 1;
      if (line_pull) pull_cyc <= pull_cyc + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_us(input int n);
      repeat (4 * n) @(negedge clk);
   endtask

   // Drive a reset low time and measure the presence pulse in clocks.
   task automatic do_reset(input int len, output int dly, output int wid);
      dly = 0;
      wid = 0;
      m_low = 1'b1;
      wait_us(len);
      m_low = 1'b0;
      while (!line_pull && dly < 2000) begin
         @(negedge clk);
         dly++;
      end
      while (line_pull && wid < 2000) begin
         @(negedge clk);
         wid++;
      end
      wait_us(10);
   endtask

   task automatic wbit(input logic b);
      m_low = 1'b1;
      wait_us(b ? 5 : 60);
      m_low = 1'b0;
      wait_us(b ? 70 : 15);
   endtask

   task automatic wbyte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) wbit(v[i]);
   endtask

   task automatic rbit(output logic b, output logic released);
      m_low = 1'b1;
      wait_us(2);
      m_low = 1'b0;
      wait_us(13);
      b = line;
      wait_us(25);
      released = line;
      wait_us(35);
   endtask

   task automatic rbyte(output logic [7:0] v, output logic all_rel);
      logic b, r;
      all_rel = 1'b1;
      for (int i = 0; i < 8; i++) begin
         rbit(b, r);
         v[i] = b;
         all_rel = all_rel & r;
      end
   endtask

   initial begin
      int dly, wid, n0, k0;
      logic [7:0] got, exp_v;
      logic rel;

      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Reset state
      chk("R9 idle pull", int'(line_pull), 0);
      chk("R6 idle func_phase", int'(func_phase), 0);
      chk("R6 idle rx_strobe", int'(rx_strobe), 0);

      // R11: 479 us is below the reset threshold
      pull_cyc = 0;
      m_low = 1'b1;
      wait_us(479);
      m_low = 1'b0;
      wait_us(200);
      chk("R11 no presence after 479us", pull_cyc, 0);

      // R1/R2: 480 us gives presence 30 us later, 120 us long
      do_reset(480, dly, wid);
      chk_rng("R2 presence delay clocks", dly, 4 * 29, 4 * 31 + 8);
      chk_rng("R2 presence width clocks", wid, 4 * 119, 4 * 121);
      chk("R1 func_phase after reset", int'(func_phase), 0);

      // R6: skip addressing opens the function phase
      wbyte(8'hCC);
      chk("R6 func_phase after 0xCC", int'(func_phase), 1);

      // R3/R5/R6/R9: sweep of written bytes, LSB first
      pull_cyc = 0;
      for (int i = 0; i < 16; i++) begin
         exp_v = 8'((i * 37 + 5) & 8'hFF);
         n0 = rx_n;
         wbyte(exp_v);
         wait_us(2);
         chk("R6 rx_strobe count", rx_n - n0, 1);
         chk("R3 R5 rx_byte value", int'(rx_last), int'(exp_v));
      end
      chk("R9 no pull during write slots", pull_cyc, 0);

      // R4/R5/R10: read slots
      tx_mode = 1'b1;
      for (int i = 0; i < 8; i++) begin
         exp_v = 8'((i * 73 + 1) & 8'hFF);
         if (i == 6) exp_v = 8'h00;
         if (i == 7) exp_v = 8'hFF;
         tx_byte = exp_v;
         k0 = tk_n;
         rbyte(got, rel);
         wait_us(2);
         chk("R4 R5 read byte", int'(got), int'(exp_v));
         chk("R4 line released by 40us", int'(rel), 1);
         chk("R10 tx_taken count", tk_n - k0, 1);
      end
      tx_mode = 1'b0;

      // R8: reset in the middle of a byte
      wbit(1'b0);
      wbit(1'b1);
      wbit(1'b1);
      do_reset(500, dly, wid);
      chk_rng("R8 presence after mid-byte reset", wid, 4 * 119, 4 * 121);
      chk("R8 func_phase cleared", int'(func_phase), 0);
      wbyte(8'hCC);
      chk("R8 skip decoded from bit 0", int'(func_phase), 1);
      n0 = rx_n;
      wbyte(8'h3C);
      wait_us(2);
      chk("R8 rx count after reset", rx_n - n0, 1);
      chk("R8 rx_byte after reset", int'(rx_last), 8'h3C);

      // R7: any other selection code keeps the device silent
      do_reset(480, dly, wid);
      wbyte(8'h33);
      chk("R7 func_phase stays 0", int'(func_phase), 0);
      n0 = rx_n;
      wbyte(8'h55);
      wait_us(2);
      chk("R7 no rx_strobe", rx_n - n0, 0);
      tx_mode = 1'b1;
      tx_byte = 8'h00;
      pull_cyc = 0;
      k0 = tk_n;
      rbyte(got, rel);
      chk("R7 read gives all ones", int'(got), 8'hFF);
      chk("R7 no pull", pull_cyc, 0);
      chk("R7 no tx_taken", tk_n - k0, 0);
      tx_mode = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule